// File: doc/BRIEF.md
# UART Receive Software Flow-Control Detector

This block sits on the path from a UART receiver's character output to the receive FIFO. Each received character is compared against four programmable flow codes: two resume codes and two stop codes. From that comparison the block decides whether the character reaches the FIFO, whether the local transmitter must pause, and whether the stop-code interrupt flag is raised. A paired mode recognises a stop or resume only when two codes arrive back to back. In that mode the first code of a pair is held back. It is written to the FIFO later if the second code does not follow. An optional resume-on-anything mode and an optional non-halting special-character alert extend the basic scheme.

The receiver pulses `rx_valid` once per character. Consecutive strobes must be at least one idle cycle apart, which any serial receiver satisfies by a wide margin. Every FIFO write appears as a one-cycle `fifo_wr` pulse. A broken pair produces two writes on successive cycles.

The transmitter reads `tx_pause` and stops only after it finishes the character it is currently sending.

Top module: `uswf_rx_flow`

## Requirements
- R1: With `flow_mode` = 2'b00 every character is written to the FIFO unchanged, one cycle after its strobe, and `tx_pause` is not affected.
- R2: With `flow_mode` = 2'b10, `code_stop_a` sets `tx_pause` and `code_go_a` clears it. With 2'b01, `code_stop_b` and `code_go_b` do the same. The change is visible one cycle after the strobe.
- R3: With `flow_mode` = 2'b11, a stop is recognised only when `code_stop_a` is immediately followed by `code_stop_b`. A resume is recognised only when `code_go_a` is immediately followed by `code_go_b`.
- R4: A recognised stop sets the interrupt flag `stop_irq` only while `stop_irq_en` is 1. `irq_n` is low exactly while `stop_irq` is high.
- R5: A recognised resume clears both `tx_pause` and `stop_irq`.
- R6: A character with any bit of `rx_err` set is never a flow code. It is written to the FIFO and it cancels a partly received pair.
- R7: When `any_go_en` and `spec_en` are both 0, characters that form a recognised stop or resume, including both halves of a completed pair, are not written. When either enable is 1, those characters are written.
- R8: In paired mode with suppression active, a first-half code followed by a character that does not complete the pair is written one cycle after that character's strobe. The character itself, if it is forwarded, is written on the next cycle. No cycle carries more than one write.
- R9: With `any_go_en` = 1 while `tx_pause` is set, the next character of any value clears `tx_pause` and `stop_irq`. That character is written, and it is not evaluated as a flow code.
- R10: With `spec_en` = 1, a character that is not part of a recognised stop or resume and equals `code_stop_b` sets `stop_irq` when `stop_irq_en` is 1. It leaves `tx_pause` unchanged and is written to the FIFO.
- R11: A pulse on `isr_rd` clears `stop_irq`. A flag set caused by a character in the same cycle takes priority, and the flag stays set.
- R12: After reset, `fifo_wr` = 0, `tx_pause` = 0, `stop_irq` = 0 and `irq_n` = 1, with no held or pending character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_char | input | 8 | Received character |
| rx_err | input | 3 | Parity, framing and break error flags of the character |
| flow_mode | input | 2 | 00 off, 01 single B codes, 10 single A codes, 11 A-then-B pairs |
| any_go_en | input | 1 | Any character resumes a paused transmitter |
| spec_en | input | 1 | Enable special-character alert on `code_stop_b` |
| stop_irq_en | input | 1 | Allow stop events to set the interrupt flag |
| code_go_a | input | 8 | First resume code |
| code_go_b | input | 8 | Second resume code |
| code_stop_a | input | 8 | First stop code |
| code_stop_b | input | 8 | Second stop code / special character |
| isr_rd | input | 1 | Interrupt status read strobe, clears the flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Character written to the FIFO |
| tx_pause | output | 1 | Transmit-halt request |
| stop_irq | output | 1 | Stop interrupt flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two events can collide in one clock. The first is a status read on `isr_rd` in the same cycle as a character strobe that sets the flag. The bench provokes this by pulsing the read together with a stop code and with a special character, and expects the flag still to be set afterwards.

The second collision comes from a broken pair. Flushing the held first half and forwarding the breaking character compete for the single write port. The bench sends a first-half code followed by a plain character. It then expects the held code on the first cycle and the plain character on the next, and random streams rich in flow codes repeat both situations against a model in the bench.

// File: rtl/uswf_pkg.sv
package uswf_pkg;
  parameter int CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;

  localparam logic [1:0] MD_OFF  = 2'b00;
  localparam logic [1:0] MD_SNGB = 2'b01;
  localparam logic [1:0] MD_SNGA = 2'b10;
  localparam logic [1:0] MD_PAIR = 2'b11;

  typedef enum logic [1:0] {PR_IDLE, PR_GO1, PR_STOP1} pair_e;

  // Does character c finish a code in mode md, given the pair progress pr?
  function automatic logic code_hit(input logic [1:0] md, input pair_e pr,
                                    input pair_e need, input char_t c,
                                    input char_t a, input char_t b);
    case (md)
      MD_SNGA: code_hit = (c == a);
      MD_SNGB: code_hit = (c == b);
      MD_PAIR: code_hit = (pr == need) && (c == b);
      default: code_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uswf_classify.sv
module uswf_classify
  import uswf_pkg::*;
#(parameter int ERR_W = 3)
(
  input  logic             rx_valid,
  input  char_t            rx_char,
  input  logic [ERR_W-1:0] rx_err,
  input  logic [1:0]       flow_mode,
  input  logic             any_go_en,
  input  logic             spec_en,
  input  char_t            code_go_a,
  input  char_t            code_go_b,
  input  char_t            code_stop_a,
  input  char_t            code_stop_b,
  input  logic             paused,
  input  pair_e            pair_q,
  input  logic             held_v,
  output logic             ev_go,
  output logic             ev_stop,
  output logic             ev_any,
  output logic             ev_spec,
  output logic             new_wr,
  output logic             hold_new,
  output logic             flush,
  output pair_e            pair_d
);
  logic suppress, complete, go_hit, stop_hit;

  assign suppress = !any_go_en && !spec_en;
  assign go_hit   = code_hit(flow_mode, pair_q, PR_GO1, rx_char, code_go_a, code_go_b);
  assign stop_hit = code_hit(flow_mode, pair_q, PR_STOP1, rx_char, code_stop_a, code_stop_b);

  always_comb begin
    ev_go = 1'b0; ev_stop = 1'b0; ev_any = 1'b0; ev_spec = 1'b0;
    new_wr = 1'b0; hold_new = 1'b0; complete = 1'b0; pair_d = PR_IDLE;
    if (rx_valid) begin
      if (flow_mode == MD_OFF) begin
        new_wr = 1'b1;
      end else if (paused && any_go_en) begin
        ev_any = 1'b1;
        new_wr = 1'b1;
      end else if (|rx_err) begin
        new_wr = 1'b1;
      end else if (go_hit) begin
        ev_go    = 1'b1;
        new_wr   = !suppress;
        complete = (flow_mode == MD_PAIR);
      end else if (stop_hit) begin
        ev_stop  = 1'b1;
        new_wr   = !suppress;
        complete = (flow_mode == MD_PAIR);
      end else if (flow_mode == MD_PAIR &&
                   (rx_char == code_go_a || rx_char == code_stop_a)) begin
        pair_d   = (rx_char == code_go_a) ? PR_GO1 : PR_STOP1;
        hold_new = suppress;
        new_wr   = !suppress;
      end else begin
        new_wr  = 1'b1;
        ev_spec = spec_en && (rx_char == code_stop_b);
      end
    end
  end

  assign flush = rx_valid && held_v && !complete;
endmodule

// File: rtl/uswf_ctrl.sv
module uswf_ctrl
  import uswf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_valid,
  input  char_t rx_char,
  input  logic  ev_go,
  input  logic  ev_stop,
  input  logic  ev_any,
  input  logic  ev_spec,
  input  logic  hold_new,
  input  pair_e pair_d,
  input  logic  stop_irq_en,
  input  logic  isr_rd,
  output logic  flag_set,
  output logic  paused,
  output logic  flag_q,
  output pair_e pair_q,
  output logic  held_v,
  output char_t held_c
);
  logic flag_clr;

  assign flag_set = (ev_stop || ev_spec) && stop_irq_en;
  assign flag_clr = ev_go || ev_any || isr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused <= 1'b0;
      flag_q <= 1'b0;
      pair_q <= PR_IDLE;
      held_v <= 1'b0;
      held_c <= '0;
    end else begin
      if (ev_stop)              paused <= 1'b1;
      else if (ev_go || ev_any) paused <= 1'b0;
      if (flag_set)             flag_q <= 1'b1;
      else if (flag_clr)        flag_q <= 1'b0;
      if (rx_valid) begin
        pair_q <= pair_d;
        held_v <= hold_new;
        held_c <= rx_char;
      end
    end
  end
endmodule

// File: rtl/uswf_wrq.sv
module uswf_wrq
  import uswf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  new_wr,
  input  char_t held_c,
  input  char_t rx_char,
  output logic  fifo_wr,
  output char_t fifo_data
);
  logic  pend_v;
  char_t pend_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
      pend_v    <= 1'b0;
      pend_c    <= '0;
    end else if (flush) begin
      fifo_wr   <= 1'b1;
      fifo_data <= held_c;
      pend_v    <= new_wr;
      pend_c    <= rx_char;
    end else if (new_wr) begin
      fifo_wr   <= 1'b1;
      fifo_data <= rx_char;
      pend_v    <= 1'b0;
    end else if (pend_v) begin
      fifo_wr   <= 1'b1;
      fifo_data <= pend_c;
      pend_v    <= 1'b0;
    end else begin
      fifo_wr   <= 1'b0;
    end
  end
endmodule

// File: rtl/uswf_rx_flow.sv
module uswf_rx_flow
  import uswf_pkg::*;
#(parameter int ERR_W = 3)
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  input  logic [ERR_W-1:0] rx_err,
  input  logic [1:0]       flow_mode,
  input  logic             any_go_en,
  input  logic             spec_en,
  input  logic             stop_irq_en,
  input  logic [7:0]       code_go_a,
  input  logic [7:0]       code_go_b,
  input  logic [7:0]       code_stop_a,
  input  logic [7:0]       code_stop_b,
  input  logic             isr_rd,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  output logic             tx_pause,
  output logic             stop_irq,
  output logic             irq_n
);
  logic  ev_go, ev_stop, ev_any, ev_spec, new_wr, hold_new, flush, flag_set;
  logic  held_v;
  char_t held_c;
  pair_e pair_q, pair_d;

  uswf_classify #(.ERR_W(ERR_W)) u_cls (
    .rx_valid(rx_valid), .rx_char(rx_char), .rx_err(rx_err),
    .flow_mode(flow_mode), .any_go_en(any_go_en), .spec_en(spec_en),
    .code_go_a(code_go_a), .code_go_b(code_go_b),
    .code_stop_a(code_stop_a), .code_stop_b(code_stop_b),
    .paused(tx_pause), .pair_q(pair_q), .held_v(held_v),
    .ev_go(ev_go), .ev_stop(ev_stop), .ev_any(ev_any), .ev_spec(ev_spec),
    .new_wr(new_wr), .hold_new(hold_new), .flush(flush), .pair_d(pair_d));

  uswf_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .ev_go(ev_go), .ev_stop(ev_stop), .ev_any(ev_any), .ev_spec(ev_spec),
    .hold_new(hold_new), .pair_d(pair_d), .stop_irq_en(stop_irq_en),
    .isr_rd(isr_rd), .flag_set(flag_set), .paused(tx_pause),
    .flag_q(stop_irq), .pair_q(pair_q), .held_v(held_v), .held_c(held_c));

  uswf_wrq u_wrq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .new_wr(new_wr),
    .held_c(held_c), .rx_char(rx_char), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data));

  assign irq_n = !stop_irq;
endmodule

// File: rtl/uswf_rx_flow_chk.sv
module uswf_rx_flow_chk #(parameter int ERR_W = 3) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [7:0]       rx_char,
  input logic [ERR_W-1:0] rx_err,
  input logic [1:0]       flow_mode,
  input logic             any_go_en,
  input logic             stop_irq_en,
  input logic             isr_rd,
  input logic             fifo_wr,
  input logic [7:0]       fifo_data,
  input logic             tx_pause,
  input logic             stop_irq,
  input logic             ev_spec,
  input logic             flag_set,
  input logic             held_v,
  input logic             flush,
  input logic             new_wr
);
  p_pause_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(rx_valid));

  p_flag_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_irq) |-> $past(stop_irq_en));

  p_off_passes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && flow_mode == 2'b00 && !held_v) |=>
      (fifo_wr && fifo_data == $past(rx_char)));

  p_err_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && |rx_err) |=> fifo_wr);

  p_any_resumes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && tx_pause && any_go_en && flow_mode != 2'b00) |=> !tx_pause);

  p_spec_keeps_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_spec |=> (tx_pause == $past(tx_pause)));

  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !flag_set) |=> !stop_irq);

  p_two_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && new_wr) |=> fifo_wr ##1 (fifo_wr && fifo_data == $past(rx_char, 2)));
endmodule

bind uswf_rx_flow uswf_rx_flow_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
  .rx_err(rx_err), .flow_mode(flow_mode), .any_go_en(any_go_en),
  .stop_irq_en(stop_irq_en), .isr_rd(isr_rd), .fifo_wr(fifo_wr),
  .fifo_data(fifo_data), .tx_pause(tx_pause), .stop_irq(stop_irq),
  .ev_spec(ev_spec), .flag_set(flag_set), .held_v(held_v), .flush(flush),
  .new_wr(new_wr));

// File: tb/uswf_rx_flow_tb.sv
module uswf_rx_flow_tb;
  localparam logic [7:0] GA = 8'h11, GB = 8'h13, SA = 8'h91, SB = 8'h93;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, any_go_en = 1'b0, spec_en = 1'b0, stop_irq_en = 1'b1, isr_rd = 1'b0;
  logic [7:0] rx_char = '0;
  logic [2:0] rx_err = '0;
  logic [1:0] flow_mode = 2'b00;
  logic fifo_wr, tx_pause, stop_irq, irq_n;
  logic [7:0] fifo_data;

  int n_run = 0, n_fail = 0;

  // bench model state
  logic m_pause, m_flag, m_hv;
  logic [7:0] m_hc;
  int m_pair;

  always #2 clk = ~clk;

  uswf_rx_flow u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_err(rx_err), .flow_mode(flow_mode), .any_go_en(any_go_en),
    .spec_en(spec_en), .stop_irq_en(stop_irq_en), .code_go_a(GA),
    .code_go_b(GB), .code_stop_a(SA), .code_stop_b(SB), .isr_rd(isr_rd),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .tx_pause(tx_pause),
    .stop_irq(stop_irq), .irq_n(irq_n));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] md, input logic anyg, input logic sp, input logic ie);
    @(negedge clk);
    rst_n = 1'b0; flow_mode = md; any_go_en = anyg; spec_en = sp; stop_irq_en = ie;
    m_pause = 0; m_flag = 0; m_hv = 0; m_hc = 0; m_pair = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // is the character a single-code match for the mode (first/second code pair)
  function automatic logic single_hit(input logic [1:0] md, input logic [7:0] c,
                                      input logic [7:0] a, input logic [7:0] b);
    return (md == 2'b10 && c == a) || (md == 2'b01 && c == b);
  endfunction

  task automatic model(input logic [7:0] c, input logic [2:0] e, input logic rd,
                       output logic w1, output logic [7:0] d1,
                       output logic w2, output logic [7:0] d2);
    logic nw, done, hold, setf, clrf, supp;
    int np;
    nw = 0; done = 0; hold = 0; setf = 0; clrf = rd; np = 0;
    supp = !any_go_en && !spec_en;
    if (flow_mode == 2'b00) nw = 1;
    else if (m_pause && any_go_en) begin nw = 1; m_pause = 0; clrf = 1; end
    else if (e != 0) nw = 1;
    else if (single_hit(flow_mode, c, GA, GB) || (flow_mode == 2'b11 && m_pair == 1 && c == GB)) begin
      m_pause = 0; clrf = 1; nw = !supp; done = (flow_mode == 2'b11);
    end else if (single_hit(flow_mode, c, SA, SB) || (flow_mode == 2'b11 && m_pair == 2 && c == SB)) begin
      m_pause = 1; setf = stop_irq_en; nw = !supp; done = (flow_mode == 2'b11);
    end else if (flow_mode == 2'b11 && (c == GA || c == SA)) begin
      np = (c == GA) ? 1 : 2; hold = supp; nw = !supp;
    end else begin
      nw = 1; setf = spec_en && stop_irq_en && (c == SB);
    end
    if (setf) m_flag = 1; else if (clrf) m_flag = 0;
    if (m_hv && !done) begin w1 = 1; d1 = m_hc; w2 = nw; d2 = c; end
    else begin w1 = nw; d1 = c; w2 = 0; d2 = 0; end
    m_pair = np; m_hv = hold; m_hc = c;
  endtask

  task automatic send(input logic [7:0] c, input logic [2:0] e, input logic rd, input string req);
    logic w1, w2;
    logic [7:0] d1, d2;
    rx_valid = 1; rx_char = c; rx_err = e; isr_rd = rd;
    model(c, e, rd, w1, d1, w2, d2);
    @(negedge clk);
    rx_valid = 0; isr_rd = 0; rx_err = 0;
    chk(fifo_wr == w1 && (!w1 || fifo_data == d1), req, {fifo_wr, fifo_data}, {w1, d1});
    chk(tx_pause == m_pause, req, tx_pause, m_pause);
    chk(stop_irq == m_flag && irq_n == !m_flag, req, {stop_irq, irq_n}, {m_flag, !m_flag});
    @(negedge clk);
    chk(fifo_wr == w2 && (!w2 || fifo_data == d2), req, {fifo_wr, fifo_data}, {w2, d2});
    @(negedge clk);
  endtask

  task automatic read_isr(input string req);
    isr_rd = 1;
    @(negedge clk);
    isr_rd = 0;
    m_flag = 0;
    chk(stop_irq == 0 && irq_n == 1, req, stop_irq, 0);
  endtask

  function automatic logic [7:0] pick();
    int k = $urandom_range(0, 5);
    case (k)
      0: return GA; 1: return GB; 2: return SA; 3: return SB;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R12 reset state
    do_reset(2'b00, 0, 0, 1);
    chk(fifo_wr == 0 && tx_pause == 0 && stop_irq == 0 && irq_n == 1, "R12", {fifo_wr, tx_pause, stop_irq}, 0);
    // R1 off mode forwards codes
    send(SA, 0, 0, "R1"); send(8'h41, 0, 0, "R1");
    // R2/R4/R5 single A codes
    do_reset(2'b10, 0, 0, 1);
    send(SA, 0, 0, "R2 R4 R7"); send(8'h42, 0, 0, "R2"); send(GA, 0, 0, "R5 R7");
    // R4 flag disabled
    do_reset(2'b10, 0, 0, 0);
    send(SA, 0, 0, "R4");
    // R2 single B codes
    do_reset(2'b01, 0, 0, 1);
    send(SB, 0, 0, "R2"); send(GB, 0, 0, "R2");
    // R3 pairs, R8 broken pair
    do_reset(2'b11, 0, 0, 1);
    send(SA, 0, 0, "R3"); send(SB, 0, 0, "R3 R7");
    send(GA, 0, 0, "R3"); send(8'h55, 0, 0, "R8");
    send(GA, 0, 0, "R3"); send(GB, 0, 0, "R3 R5");
    send(SA, 0, 0, "R8"); send(SA, 0, 0, "R8"); send(SB, 0, 0, "R8");
    // R6 error breaks pair and is forwarded
    send(GA, 0, 0, "R6"); send(GB, 3'b010, 0, "R6");
    do_reset(2'b10, 0, 0, 1);
    send(SA, 3'b001, 0, "R6");
    // R9 any resumes
    do_reset(2'b10, 1, 0, 1);
    send(SA, 0, 0, "R9 R7"); send(SA, 0, 0, "R9");
    // R10 special, R11 read and collision
    do_reset(2'b10, 0, 1, 1);
    send(SB, 0, 0, "R10"); read_isr("R11");
    send(SB, 0, 1, "R11"); send(SA, 0, 1, "R11"); read_isr("R11");
    // random streams across configurations
    for (int cfg = 0; cfg < 32; cfg++) begin
      do_reset(2'(cfg), cfg[2], cfg[3], cfg[4] | cfg[0]);
      for (int i = 0; i < 40; i++) begin
        logic [2:0] e;
        e = ($urandom_range(0, 9) == 0) ? 3'(1 << $urandom_range(0, 2)) : 3'b000;
        send(pick(), e, $urandom_range(0, 7) == 0, "R1 R2 R3 R6 R7 R8 R9 R10 random");
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule